// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core that switches between seven operating modes. Software always names sixteen registers, r0 to r15, but the storage behind some of those names changes with the mode, so that an exception handler finds its own stack pointer and link register without saving the interrupted code's copies first. Behind the sixteen names sit 31 physical data words. There is also one current status word, and there are five saved status words, one for each exception mode. That makes 37 physical words in total.

The mode in effect is the low five bits of the current status word. Two read ports and one write port are addressed by architectural number and are remapped through that mode. A status port reads and writes the current status word. A saved-status port reads and writes the saved status word of the current mode. An exception-entry strobe records the current status in the target mode's saved status word and switches the mode field to the target mode in one clock. Instruction decode, the ALU and instruction fetch sit outside the block. r15 is held here as a plain register slot.

Top module: `banked_regfile`

## Requirements
- R1: After reset every data register holds zero, the current status word holds 0x000000D3 (supervisor mode, bits 7 and 6 set), and the saved-status port reads zero.
- R2: The mode is status bits [4:0]. The encodings are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Any other value behaves as user mode for register access and has no saved status word.
- R3: r0 to r7 and r15 each have a single physical copy that every mode reads and writes.
- R4: Fast-interrupt mode has its own r8 to r14. Writes to these in that mode never change what other modes read, and writes from other modes never change them.
- R5: Interrupt, supervisor, abort and undefined modes each have their own r13 and r14. They share r8 to r12 with user mode.
- R6: System mode accesses exactly the user-mode registers.
- R7: The saved-status port reads and writes the saved status word of the current mode when that mode is one of the five exception modes. In user mode, system mode or an unlisted mode it reads zero, and a write there changes no saved status word.
- R8: Exception entry to one of the five exception modes copies the current status into that mode's saved status word. It replaces status bits [4:0] with the target encoding and keeps bits [31:5]. In that cycle it takes priority over the status and saved-status writes. An entry strobe naming any other mode has no effect, and the writes of that cycle proceed.
- R9: Reads are combinational and writes take effect at the clock edge. A read of the register being written in the same cycle returns the old value.
- R10: A register write and a saved-status write use the mode in effect during their cycle, even when the status word changes mode at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| sr_wr_en | input | 1 | Current status write enable |
| sr_wr_data | input | 32 | New current status |
| sr_rd_data | output | 32 | Current status word |
| ssr_wr_en | input | 1 | Saved status write enable (current mode) |
| ssr_wr_data | input | 32 | New saved status |
| ssr_rd_data | output | 32 | Saved status of the current mode, or zero |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode encoding for the entry |

## Verification
A wrong bank mapping does not show when the write happens. It shows later, when a different mode reads a register whose value it should not share, or fails to see one it should share. The bench therefore keeps a separate model copy per bank and compares both read ports in every cycle, under random mode changes. An exception entry that copies the status badly, or into the wrong slot, shows on the saved-status port on the first cycle after the edge, because the port then already names the target mode. A write that used the post-change mode only appears when the old mode is entered again.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int NUM_ARCH      = 16;
    localparam int NUM_FIQ_PRIV  = 7;
    localparam int NUM_EXC_BANKS = 4;
    localparam int NUM_PHYS      = NUM_ARCH + NUM_FIQ_PRIV + 2 * NUM_EXC_BANKS;
    localparam int PHYS_W        = $clog2(NUM_PHYS);
    localparam int NUM_SSR       = NUM_EXC_BANKS + 1;
    localparam int SSR_W         = $clog2(NUM_SSR);
    localparam int FIQ_BASE      = NUM_ARCH;
    localparam int EXC_BASE      = NUM_ARCH + NUM_FIQ_PRIV;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

endpackage

// File: rtl/bankrf_mode_dec.sv
module bankrf_mode_dec
    import bankrf_pkg::*;
(
    input  logic [4:0]       mode,
    output bank_e            bank,
    output logic             has_ssr,
    output logic [SSR_W-1:0] ssr_slot
);

    always_comb begin
        case (mode)
            MODE_FIQ: bank = BK_FIQ;
            MODE_IRQ: bank = BK_IRQ;
            MODE_SVC: bank = BK_SVC;
            MODE_ABT: bank = BK_ABT;
            MODE_UND: bank = BK_UND;
            default:  bank = BK_USR;   // user, system and unlisted encodings
        endcase
        has_ssr  = (bank != BK_USR);
        ssr_slot = has_ssr ? SSR_W'(bank - 3'd1) : '0;
    end

endmodule

// File: rtl/bankrf_idx_map.sv
module bankrf_idx_map
    import bankrf_pkg::*;
(
    input  bank_e             bank,
    input  logic [3:0]        arch,
    output logic [PHYS_W-1:0] phys
);

    logic fiq_range;
    logic sp_lr;

    always_comb begin
        fiq_range = (arch >= 4'd8) && (arch <= 4'd14);
        sp_lr     = (arch == 4'd13) || (arch == 4'd14);
        phys      = PHYS_W'(arch);
        if (bank == BK_FIQ) begin
            if (fiq_range)
                phys = PHYS_W'(FIQ_BASE) + PHYS_W'(arch - 4'd8);
        end else if (bank != BK_USR) begin
            if (sp_lr)
                phys = PHYS_W'(EXC_BASE)
                     + PHYS_W'({bank - BK_IRQ, 1'b0})
                     + PHYS_W'(arch - 4'd13);
        end
    end

endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
    import bankrf_pkg::*;
#(
    parameter int          DW       = 32,
    parameter logic [31:0] RESET_SR = 32'h0000_00D3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sr_we,
    input  logic [DW-1:0] sr_wdata,
    input  logic          ssr_we,
    input  logic [DW-1:0] ssr_wdata,
    input  logic          exc_en,
    input  logic [4:0]    exc_mode,
    output logic [DW-1:0] sr_rdata,
    output logic [DW-1:0] ssr_rdata,
    output bank_e         cur_bank
);

    typedef struct packed {
        logic [DW-1:0]              sr;
        logic [NUM_SSR-1:0][DW-1:0] ssr;
    } stat_t;

    stat_t st_d, st_q;

    logic             cur_has, tgt_has;
    logic [SSR_W-1:0] cur_slot, tgt_slot;
    bank_e            tgt_bank;

    bankrf_mode_dec u_cur_dec (
        .mode     (st_q.sr[4:0]),
        .bank     (cur_bank),
        .has_ssr  (cur_has),
        .ssr_slot (cur_slot)
    );

    bankrf_mode_dec u_tgt_dec (
        .mode     (exc_mode),
        .bank     (tgt_bank),
        .has_ssr  (tgt_has),
        .ssr_slot (tgt_slot)
    );

    always_comb begin
        st_d = st_q;
        if (exc_en && tgt_has) begin
            st_d.ssr[tgt_slot] = st_q.sr;
            st_d.sr[4:0]       = exc_mode;
        end else begin
            if (sr_we)
                st_d.sr = sr_wdata;
            if (ssr_we && cur_has)
                st_d.ssr[cur_slot] = ssr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= DW'(RESET_SR);
            st_q.ssr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_rdata  = st_q.sr;
    assign ssr_rdata = cur_has ? st_q.ssr[cur_slot] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int          DW       = 32,
    parameter logic [31:0] RESET_SR = 32'h0000_00D3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          sr_wr_en,
    input  logic [DW-1:0] sr_wr_data,
    output logic [DW-1:0] sr_rd_data,
    input  logic          ssr_wr_en,
    input  logic [DW-1:0] ssr_wr_data,
    output logic [DW-1:0] ssr_rd_data,
    input  logic          exc_en,
    input  logic [4:0]    exc_mode
);

    localparam int NPORT = 3;   // read A, read B, write

    typedef struct packed {
        logic [NUM_PHYS-1:0][DW-1:0] gpr;
    } file_t;

    file_t file_d, file_q;
    bank_e cur_bank;

    logic [NPORT-1:0][3:0]        port_arch;
    logic [NPORT-1:0][PHYS_W-1:0] port_phys;

    assign port_arch[0] = rd_a_idx;
    assign port_arch[1] = rd_b_idx;
    assign port_arch[2] = wr_idx;

    bankrf_status #(.DW(DW), .RESET_SR(RESET_SR)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_we     (sr_wr_en),
        .sr_wdata  (sr_wr_data),
        .ssr_we    (ssr_wr_en),
        .ssr_wdata (ssr_wr_data),
        .exc_en    (exc_en),
        .exc_mode  (exc_mode),
        .sr_rdata  (sr_rd_data),
        .ssr_rdata (ssr_rd_data),
        .cur_bank  (cur_bank)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bankrf_idx_map u_map (
            .bank (cur_bank),
            .arch (port_arch[p]),
            .phys (port_phys[p])
        );
    end

    always_comb begin
        file_d = file_q;
        if (wr_en)
            file_d.gpr[port_phys[2]] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            file_q <= '0;
        else
            file_q <= file_d;
    end

    assign rd_a_data = file_q.gpr[port_phys[0]];
    assign rd_b_data = file_q.gpr[port_phys[1]];

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        sr_wr_en,
    input logic [31:0] sr_rd_data,
    input logic [31:0] ssr_rd_data,
    input logic        exc_en,
    input logic [4:0]  exc_mode
);

    function automatic logic owns_ssr(input logic [4:0] m);
        return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011)
            || (m == 5'b10111) || (m == 5'b11011);
    endfunction

    a_r7_ssr_zero_unbanked: assert property (@(posedge clk) disable iff (!rst_n)
        !owns_ssr(sr_rd_data[4:0]) |-> (ssr_rd_data == 32'd0));

    a_r8_entry_copies_status: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && owns_ssr(exc_mode)) |=>
            (ssr_rd_data == $past(sr_rd_data)) &&
            (sr_rd_data[4:0] == $past(exc_mode)) &&
            (sr_rd_data[31:5] == $past(sr_rd_data[31:5])));

    a_r8_bad_target_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && !owns_ssr(exc_mode) && !sr_wr_en) |=>
            (sr_rd_data == $past(sr_rd_data)));

    a_r3_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15) |=>
            ((rd_a_idx != 4'd15) || (rd_a_data == $past(wr_data))));

    a_r9_read_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(rd_a_idx) && $stable(sr_rd_data[4:0]))
            |-> $stable(rd_a_data));

endmodule

bind banked_regfile bankrf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .sr_wr_en    (sr_wr_en),
    .sr_rd_data  (sr_rd_data),
    .ssr_rd_data (ssr_rd_data),
    .exc_en      (exc_en),
    .exc_mode    (exc_mode)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, sr_wr_en = 1'b0, ssr_wr_en = 1'b0, exc_en = 1'b0;
    logic [31:0] sr_wr_data = '0, ssr_wr_data = '0, sr_rd_data, ssr_rd_data;
    logic [4:0]  exc_mode = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .ssr_wr_en(ssr_wr_en), .ssr_wr_data(ssr_wr_data), .ssr_rd_data(ssr_rd_data),
        .exc_en(exc_en), .exc_mode(exc_mode)
    );

    // ---------------- reference model, one array per bank ----------------
    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];    // fast-interrupt r8..r14
    logic [31:0] m_sp  [4];    // r13 of irq, svc, abt, und
    logic [31:0] m_lr  [4];    // r14 of irq, svc, abt, und
    logic [31:0] m_sr;
    logic [31:0] m_ssr [5];    // fiq, irq, svc, abt, und

    // 0 = user bank, 1 = fast interrupt, 2..5 = irq, svc, abt, und
    function automatic int who(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] ref_rd(input logic [3:0] i, input logic [4:0] m);
        int w = who(m);
        if (w == 1 && i >= 8 && i <= 14) return m_fiq[i - 8];
        if (w >= 2 && i == 13) return m_sp[w - 2];
        if (w >= 2 && i == 14) return m_lr[w - 2];
        return m_usr[i];
    endfunction

    function automatic logic [31:0] ref_ssr(input logic [4:0] m);
        int w = who(m);
        return (w == 0) ? 32'd0 : m_ssr[w - 1];
    endfunction

    function automatic string tag_of(input logic [3:0] i, input logic [4:0] m);
        int w = who(m);
        if (w == 0 && m != 5'b10000 && m != 5'b11111) return "R2";
        if (i < 8 || i == 15) return "R3";
        if (w == 1) return "R4";
        if (m == 5'b11111) return "R6";
        return "R5";
    endfunction

    function automatic logic [4:0] pick_mode(input int r);
        case (r % 9)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            7: return 5'b00000;
            default: return 5'b10110;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_update();
        logic [31:0] old_sr = m_sr;
        int w = who(old_sr[4:0]);
        int t = who(exc_mode);
        if (wr_en) begin
            if (w == 1 && wr_idx >= 8 && wr_idx <= 14) m_fiq[wr_idx - 8] = wr_data;
            else if (w >= 2 && wr_idx == 13) m_sp[w - 2] = wr_data;
            else if (w >= 2 && wr_idx == 14) m_lr[w - 2] = wr_data;
            else m_usr[wr_idx] = wr_data;
        end
        if (exc_en && t != 0) begin
            m_ssr[t - 1] = old_sr;
            m_sr[4:0]    = exc_mode;
        end else begin
            if (sr_wr_en) m_sr = sr_wr_data;
            if (ssr_wr_en && w != 0) m_ssr[w - 1] = ssr_wr_data;
        end
    endtask

    // inputs are set just after a falling edge; this checks and advances one cycle
    task automatic step(input string ctx);
        string ta, tb;
        #2;
        ta = tag_of(rd_a_idx, m_sr[4:0]);
        tb = tag_of(rd_b_idx, m_sr[4:0]);
        if (wr_en && wr_idx == rd_a_idx) ta = "R9";
        if (wr_en && wr_idx == rd_b_idx) tb = "R9";
        if (ctx != "") begin ta = ctx; tb = ctx; end
        chk(ta, rd_a_data, ref_rd(rd_a_idx, m_sr[4:0]));
        chk(tb, rd_b_data, ref_rd(rd_b_idx, m_sr[4:0]));
        chk((ctx != "") ? ctx : "R8", sr_rd_data, m_sr);
        chk((ctx != "") ? ctx : "R7", ssr_rd_data, ref_ssr(m_sr[4:0]));
        @(posedge clk);
        ref_update();
        @(negedge clk);
        wr_en = 0; sr_wr_en = 0; ssr_wr_en = 0; exc_en = 0;
    endtask

    task automatic set_mode(input logic [4:0] m);
        sr_wr_en = 1; sr_wr_data = {m_sr[31:5], m};
        step("");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (m_usr[i]) m_usr[i] = '0;
        foreach (m_fiq[i]) m_fiq[i] = '0;
        foreach (m_sp[i])  begin m_sp[i] = '0; m_lr[i] = '0; end
        foreach (m_ssr[i]) m_ssr[i] = '0;
        m_sr = 32'h0000_00D3;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, swept over every index
        for (int i = 0; i < 16; i += 2) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i + 1);
            step("R1");
        end

        // R4 R5 R6: tag each mode's r8 and r13 with its own value, then read back in every mode
        for (int k = 0; k < 7; k++) begin
            set_mode(pick_mode(k));
            wr_en = 1; wr_idx = 4'd8;  wr_data = 32'hA000_0000 + k; step("");
            wr_en = 1; wr_idx = 4'd13; wr_data = 32'hB000_0000 + k; step("");
        end
        for (int k = 0; k < 7; k++) begin
            set_mode(pick_mode(k));
            rd_a_idx = 4'd8; rd_b_idx = 4'd13; step("");
        end

        // R7: saved-status write in system mode is dropped
        set_mode(5'b11111);
        ssr_wr_en = 1; ssr_wr_data = 32'hDEAD_BEEF; step("R7");
        rd_a_idx = 4'd0; step("R7");

        // R10: a write in the cycle that leaves supervisor lands in the supervisor bank
        set_mode(5'b10011);
        wr_en = 1; wr_idx = 4'd14; wr_data = 32'h1234_5678;
        ssr_wr_en = 1; ssr_wr_data = 32'h0F0F_0F0F;
        sr_wr_en = 1; sr_wr_data = {m_sr[31:5], 5'b10000};
        step("R10");
        rd_a_idx = 4'd14; step("R10");
        set_mode(5'b10011);
        rd_a_idx = 4'd14; step("R10");

        // R8: entry with a simultaneous status write; then an entry to user mode
        exc_en = 1; exc_mode = 5'b10111; sr_wr_en = 1; sr_wr_data = 32'h5555_5550;
        step("R8");
        step("R8");
        exc_en = 1; exc_mode = 5'b10000; step("R8");
        step("R8");

        // R9: read and write of the same register in one cycle
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'hCAFE_0003; rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        step("R9");
        step("R9");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            rd_a_idx = 4'($urandom_range(0, 15));
            rd_b_idx = 4'($urandom_range(0, 15));
            wr_en    = ($urandom_range(0, 3) != 0);
            wr_idx   = ($urandom_range(0, 3) == 0) ? rd_a_idx : 4'($urandom_range(0, 15));
            wr_data  = $urandom;
            if (r < 12) begin
                sr_wr_en = 1;
                sr_wr_data = {27'($urandom), pick_mode($urandom_range(0, 8))};
            end
            if (r >= 12 && r < 24) begin
                ssr_wr_en = 1; ssr_wr_data = $urandom;
            end
            if (r >= 24 && r < 32) begin
                exc_en = 1; exc_mode = pick_mode($urandom_range(0, 8));
            end
            step("");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule